// File: doc/BRIEF.md
# Paged Address Translation Unit

This block sits between a CPU's address output and the memory system. It turns a 32-bit request address into a physical address by looking up a page table. The 20-bit page number selects the entry, and the low 12 bits are copied through unchanged. There are two tables. Reads use one and writes use the other, so a page can be made readable but not writable. An entry whose value is zero is a null entry. A null entry does not map to memory: the access goes on to the I/O decoder. A small set of unimplemented addresses always ends in a bus error. A compatibility input selects 24-bit mode, in which the top address byte is ignored and every 16 MB region mirrors the low one.

Requests use a valid/ready handshake and are answered one cycle later through a second valid/ready pair. The control state machine has two states. ST_IDLE drives req_ready high. On an accepted request it takes the transition ACCEPT to ST_HOLD. ST_HOLD drives rsp_valid high. When rsp_ready is high it takes the transition RELEASE back to ST_IDLE. Otherwise it takes the transition WAIT and stays in ST_HOLD. Software loads the tables through a single-cycle write port, one entry per cycle. To keep simulation small, the table depth is set by the parameter IDX_BITS (default 6, so 64 pages per table), while the page-number width at the ports stays 20 bits.

Top module: `page_xlate_unit`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, and every entry of both tables is null (zero).
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. rsp_valid is 1 on the next cycle. While rsp_valid is 1, req_ready is 0 and rsp_kind and rsp_paddr stay unchanged until a cycle with rsp_ready high.
- R3: The page number is bits 31..12 of the effective address. A read whose read entry is non-zero returns rsp_kind 0 (memory) and rsp_paddr = {entry, address bits 11..0}.
- R4: Writes consult only the write table. A write whose write entry is non-zero returns rsp_kind 0 and rsp_paddr = {write entry, offset}, independent of the read entry.
- R5: A read whose read entry is null returns rsp_kind 1 (I/O route), with rsp_paddr equal to the effective address.
- R6: A write whose write entry is null returns rsp_kind 3 (write protect) if its read entry is non-zero, and rsp_kind 1 (I/O) if both entries are null. In both cases rsp_paddr is the effective address.
- R7: When bits 31..16 of the effective address equal 0x68F1, the response is rsp_kind 2 (bus error), whatever the tables hold.
- R8: A page number of 2^IDX_BITS or more gives rsp_kind 2. Page 2^IDX_BITS−1 is still translated normally.
- R9: With mode24 high when a request is accepted, the effective address is {8'h00, req_addr[23:0]}. Addresses that differ only in the top byte translate identically. With mode24 low, the effective address is req_addr.
- R10: A cycle with cfg_we high stores cfg_base into the read table (cfg_sel 0) or the write table (cfg_sel 1) at page cfg_page. It is visible to requests accepted in later cycles. A cfg_page beyond the table depth is ignored and changes no entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode24 | input | 1 | 1 selects 24-bit addressing for the accepted request |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | CPU address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_kind | output | 2 | 0 memory, 1 I/O, 2 bus error, 3 write protect |
| rsp_paddr | output | 32 | Translated or effective address |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_sel | input | 1 | 0 = read table, 1 = write table |
| cfg_page | input | 20 | Page number to load |
| cfg_base | input | 20 | Physical page base (0 = null) |

## Verification
The bench targets the priority between the unimplemented region, the out-of-range pages and the table contents. A design that ordered these checks wrongly would return memory or I/O for 0x68F1xxxx. It also checks that writes to a read-only page raise write protect and are not sent to I/O, and that reads never do so. It checks the top-byte mirror in 24-bit mode, where a design that masked the wrong bits would give a bus error or the wrong physical page. It checks that out-of-range configuration writes do not alias onto low pages, and that a held response neither changes nor lets a second request in.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
    localparam int ADDR_W = 32;
    localparam int OFF_W  = 12;
    localparam int PAGE_W = ADDR_W - OFF_W;

    typedef enum logic [1:0] {
        KIND_MEM    = 2'd0,
        KIND_IO     = 2'd1,
        KIND_BUSERR = 2'd2,
        KIND_WPROT  = 2'd3
    } xlate_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } xlate_state_e;

    function automatic logic page_fits(input logic [PAGE_W-1:0] page, input int idx_bits);
        return (page >> idx_bits) == '0;
    endfunction
endpackage

// File: rtl/pxu_table.sv
module pxu_table
    import pxu_pkg::*;
#(
    parameter int IDX_BITS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_BITS-1:0] wr_idx,
    input  logic [PAGE_W-1:0]   wr_data,
    input  logic [IDX_BITS-1:0] rd_idx,
    output logic [PAGE_W-1:0]   rd_data
);
    localparam int DEPTH = 1 << IDX_BITS;

    logic [PAGE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/pxu_classify.sv
module pxu_classify
    import pxu_pkg::*;
#(
    parameter int          IDX_BITS  = 6,
    parameter logic [15:0] UNIMP_TAG = 16'h68F1
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                write,
    input  logic                mode24,
    output logic [IDX_BITS-1:0] tbl_idx,
    input  logic [PAGE_W-1:0]   rd_entry,
    input  logic [PAGE_W-1:0]   wr_entry,
    output xlate_kind_e         kind,
    output logic [ADDR_W-1:0]   paddr
);
    logic [ADDR_W-1:0] eff;
    logic [PAGE_W-1:0] page;
    logic              in_range;
    logic              unimp;

    assign eff      = mode24 ? {8'h00, addr[23:0]} : addr;
    assign page     = eff[ADDR_W-1:OFF_W];
    assign tbl_idx  = page[IDX_BITS-1:0];
    assign in_range = page_fits(page, IDX_BITS);
    assign unimp    = (eff[ADDR_W-1:16] == UNIMP_TAG);

    always_comb begin
        kind  = KIND_IO;
        paddr = eff;
        if (unimp || !in_range) begin
            kind = KIND_BUSERR;
        end else if (!write) begin
            if (rd_entry != '0) begin
                kind  = KIND_MEM;
                paddr = {rd_entry, eff[OFF_W-1:0]};
            end
        end else begin
            if (wr_entry != '0) begin
                kind  = KIND_MEM;
                paddr = {wr_entry, eff[OFF_W-1:0]};
            end else if (rd_entry != '0) begin
                kind = KIND_WPROT;
            end
        end
    end
endmodule

// File: rtl/pxu_fsm.sv
module pxu_fsm
    import pxu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              rsp_ready,
    output logic              rsp_valid,
    input  xlate_kind_e       nxt_kind,
    input  logic [ADDR_W-1:0] nxt_paddr,
    output xlate_kind_e       rsp_kind,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              accept
);
    xlate_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nxt = ST_HOLD;
            ST_HOLD: if (rsp_ready) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_HOLD: rsp_valid = 1'b1;
            default: req_ready = 1'b0;
        endcase
    end

    assign accept = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_kind  <= KIND_IO;
            rsp_paddr <= '0;
        end else if (accept) begin
            rsp_kind  <= nxt_kind;
            rsp_paddr <= nxt_paddr;
        end
    end

    AST_ACCEPT_NEXT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid); // R2
    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R2
    AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_kind) && $stable(rsp_paddr))); // R2
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
    import pxu_pkg::*;
#(
    parameter int          IDX_BITS  = 6,
    parameter logic [15:0] UNIMP_TAG = 16'h68F1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode24,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_addr,
    input  logic        req_write,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [1:0]  rsp_kind,
    output logic [31:0] rsp_paddr,
    input  logic        cfg_we,
    input  logic        cfg_sel,
    input  logic [19:0] cfg_page,
    input  logic [19:0] cfg_base
);
    localparam int N_TBL = 2;

    logic [IDX_BITS-1:0] lookup_idx;
    logic [PAGE_W-1:0]   entry [N_TBL];
    logic                cfg_fits;
    xlate_kind_e         nxt_kind;
    xlate_kind_e         kind_q;
    logic [ADDR_W-1:0]   nxt_paddr;
    logic                accept;

    assign cfg_fits = page_fits(cfg_page, IDX_BITS);

    for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
        pxu_table #(.IDX_BITS(IDX_BITS)) u_tbl (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_we && cfg_fits && (cfg_sel == 1'(t))),
            .wr_idx  (cfg_page[IDX_BITS-1:0]),
            .wr_data (cfg_base),
            .rd_idx  (lookup_idx),
            .rd_data (entry[t])
        );
    end

    pxu_classify #(.IDX_BITS(IDX_BITS), .UNIMP_TAG(UNIMP_TAG)) u_cls (
        .addr     (req_addr),
        .write    (req_write),
        .mode24   (mode24),
        .tbl_idx  (lookup_idx),
        .rd_entry (entry[0]),
        .wr_entry (entry[1]),
        .kind     (nxt_kind),
        .paddr    (nxt_paddr)
    );

    pxu_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .rsp_ready (rsp_ready),
        .rsp_valid (rsp_valid),
        .nxt_kind  (nxt_kind),
        .nxt_paddr (nxt_paddr),
        .rsp_kind  (kind_q),
        .rsp_paddr (rsp_paddr),
        .accept    (accept)
    );

    assign rsp_kind = kind_q;

    AST_UNIMP_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !mode24 && req_addr[31:16] == UNIMP_TAG) |=> rsp_kind == 2'd2); // R7
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_paddr[11:0] == $past(req_addr[11:0])); // R3
    AST_READ_NO_WPROT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_write) |=> rsp_kind != 2'd3); // R6
    AST_MIRROR_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode24) |=> (rsp_kind == 2'd0 || rsp_paddr[31:24] == 8'h00)); // R9
endmodule

// File: tb/page_xlate_unit_test.sv
module page_xlate_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] K_MEM = 2'd0, K_IO = 2'd1, K_BERR = 2'd2, K_WP = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode24 = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [1:0]  rsp_kind;
    logic [31:0] rsp_paddr;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [19:0] cfg_page = '0;
    logic [19:0] cfg_base = '0;

    int n_run = 0;
    int n_fail = 0;

    page_xlate_unit uut (
        .clk(clk), .rst_n(rst_n), .mode24(mode24),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_paddr(rsp_paddr),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_page(cfg_page), .cfg_base(cfg_base)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic load(input logic sel, input logic [19:0] page, input logic [19:0] base);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_page = page; cfg_base = base;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic xlate(input string tag, input logic [31:0] a, input logic w, input logic m,
                         input logic [1:0] ek, input logic [31:0] ep);
        @(negedge clk);
        req_addr = a; req_write = w; mode24 = m; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R2 valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " kind"}, 32'(rsp_kind), 32'(ek));
        check({tag, " paddr"}, rsp_paddr, ep);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 req_ready", 32'(req_ready), 32'd1);
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        xlate("R1 R5 null read", 32'h0000_5ABC, 1'b0, 1'b0, K_IO, 32'h0000_5ABC);
        xlate("R1 R6 null write", 32'h0000_2004, 1'b1, 1'b0, K_IO, 32'h0000_2004);
    endtask

    task automatic t_mapped;
        load(1'b0, 20'h00003, 20'hABCDE);
        load(1'b1, 20'h00003, 20'h11111);
        xlate("R3 read map", 32'h0000_3123, 1'b0, 1'b0, K_MEM, 32'hABCD_E123);
        xlate("R4 write map", 32'h0000_3FFF, 1'b1, 1'b0, K_MEM, 32'h1111_1FFF);
    endtask

    task automatic t_protect;
        load(1'b0, 20'h00007, 20'h22222);
        xlate("R6 wprot", 32'h0000_7010, 1'b1, 1'b0, K_WP, 32'h0000_7010);
        xlate("R3 ro read", 32'h0000_7010, 1'b0, 1'b0, K_MEM, 32'h2222_2010);
        xlate("R6 both null io", 32'h0000_9008, 1'b1, 1'b0, K_IO, 32'h0000_9008);
    endtask

    task automatic t_faults;
        load(1'b0, 20'h00031, 20'h33333);
        xlate("R7 unimp read", 32'h68F1_0004, 1'b0, 1'b0, K_BERR, 32'h68F1_0004);
        xlate("R7 unimp write", 32'h68F1_FFF0, 1'b1, 1'b0, K_BERR, 32'h68F1_FFF0);
        xlate("R8 past depth", 32'h0004_0000, 1'b0, 1'b0, K_BERR, 32'h0004_0000);
        load(1'b0, 20'h0003F, 20'h0F00F);
        xlate("R8 last page", 32'h0003_F008, 1'b0, 1'b0, K_MEM, 32'h0F00_F008);
    endtask

    task automatic t_mirror;
        xlate("R9 32-bit top byte", 32'h1200_3456, 1'b0, 1'b0, K_BERR, 32'h1200_3456);
        xlate("R9 24-bit mirror", 32'h1200_3456, 1'b0, 1'b1, K_MEM, 32'hABCD_E456);
        xlate("R9 24-bit io", 32'hFF00_5010, 1'b0, 1'b1, K_IO, 32'h0000_5010);
    endtask

    task automatic t_cfg_ignore;
        load(1'b0, 20'h00041, 20'h77777);
        xlate("R10 out-of-range cfg", 32'h0000_1000, 1'b0, 1'b0, K_IO, 32'h0000_1000);
        load(1'b1, 20'h00001, 20'h44444);
        xlate("R10 write table only", 32'h0000_1000, 1'b0, 1'b0, K_IO, 32'h0000_1000);
        xlate("R10 write table load", 32'h0000_1ABC, 1'b1, 1'b0, K_MEM, 32'h4444_4ABC);
    endtask

    task automatic t_hold;
        logic [1:0]  k0;
        logic [31:0] p0;
        @(negedge clk);
        req_addr = 32'h0000_3222; req_write = 1'b0; mode24 = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_addr = 32'h0000_9000; req_write = 1'b1;
        k0 = rsp_kind; p0 = rsp_paddr;
        check("R2 first kind", 32'(k0), 32'(K_MEM));
        check("R2 first paddr", p0, 32'hABCD_E222);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R2 held valid", 32'(rsp_valid), 32'd1);
            check("R2 ready low", 32'(req_ready), 32'd0);
            check("R2 held paddr", rsp_paddr, p0);
        end
        req_valid = 1'b0;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check("R2 no second accept", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mapped();
        t_protect();
        t_faults();
        t_mirror();
        t_cfg_ignore();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule